// File: doc/BRIEF.md
# Correlating Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a global record of the most recent branch outcomes. That record is combined with low-order bits of the branch address to select one saturating counter from an untagged table. A fetch stage presents a branch address on the lookup port and receives a taken or not-taken guess in the same cycle, through combinational logic only.

Once the branch resolves, the back end presents its address and real outcome on the training port. The counter that the lookup would have used is moved one step toward the outcome. The outcome is then pushed into the global record.

A parameter picks how the table index is formed. In joined mode, the address bits and the history sit side by side. In folded mode, the history is XORed into the address bits. The default build keeps 2 history bits and 2-bit counters in 1024 entries, which is 2048 bits of counter state.

Top module: `gbp_corr_predictor`

## Requirements
- R1: After reset every counter holds the weakly-taken value 2^(CTR_BITS-1) and the history is zero, so every address predicts taken.
- R2: A training event with outcome taken (`upd_taken`=1) raises the selected counter by one. A counter already at 2^CTR_BITS-1 stays at that value.
- R3: A training event with outcome not-taken (`upd_taken`=0) lowers the selected counter by one. A counter already at 0 stays at 0.
- R4: `pred_taken` is 1 exactly when the selected counter is at least 2^(CTR_BITS-1).
- R5: Each training event shifts the history left by one and puts the outcome in bit 0, where 1 means taken. The oldest bit is dropped. Without a training event the history holds its value.
- R6: In joined mode (`IDX_CONCAT`), the index is {pc[PC_LSB +: IDX_W-HIST_BITS], history}. The address bits are in the upper part and the history is in the lower HIST_BITS bits.
- R7: In folded mode (`IDX_XOR`), the index is pc[PC_LSB +: IDX_W] XOR the zero-extended history.
- R8: A training event selects its counter using the history as it was before that event's own outcome is shifted in.
- R9: When a lookup and a training event occur in the same cycle, the lookup sees the table contents and the history from before the training event.
- R10: The table has no tags. Two addresses that give the same index share one counter, including addresses that differ only above the index bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | PC_W | Branch address to look up |
| pred_taken | output | 1 | Guessed direction for `pred_pc`, 1 = taken |
| upd_valid | input | 1 | A resolved branch is presented for training |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch, 1 = taken |

## Verification
A lookup and a training event can fall in the same cycle. This matters most when both land on the same counter, or when the training event changes the history the lookup uses. The bench provokes this on purpose: it runs lookup and training together for repeated and aliased addresses, and for long random streams in which the two addresses often coincide. For each lookup, the scoreboard's expected guess is formed from the model state captured before that cycle's training is applied. A design that forwards the new counter value or the new history gives a different guess, and the check reports it.

// File: rtl/gbp_pkg.sv
package gbp_pkg;

  typedef enum logic [0:0] {
    IDX_CONCAT = 1'b0,
    IDX_XOR    = 1'b1
  } idx_mode_e;

  // One saturating step of a counter whose ceiling is top_val.
  function automatic int unsigned ctr_step(input int unsigned cur,
                                           input logic up,
                                           input int unsigned top_val);
    int unsigned res;
    if (up) res = (cur >= top_val) ? top_val : cur + 1;
    else    res = (cur == 0) ? 0 : cur - 1;
    return res;
  endfunction

  // Direction read from a counter: taken when in the upper half.
  function automatic logic ctr_says_taken(input int unsigned cur,
                                          input int unsigned half_val);
    return cur >= half_val;
  endfunction

endpackage

// File: rtl/gbp_history.sv
module gbp_history #(
  parameter int HIST_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic                 shift_bit,
  output logic [HIST_BITS-1:0] hist_q
);

  logic [HIST_BITS-1:0] hist_d;

  generate
    if (HIST_BITS == 1) begin : g_one
      assign hist_d = shift_bit;
    end else begin : g_many
      assign hist_d = {hist_q[HIST_BITS-2:0], shift_bit};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)        hist_q <= '0;
    else if (shift_en) hist_q <= hist_d;
  end

endmodule

// File: rtl/gbp_index.sv
module gbp_index #(
  parameter int                PC_W      = 32,
  parameter int                PC_LSB    = 2,
  parameter int                HIST_BITS = 2,
  parameter int                IDX_W     = 10,
  parameter gbp_pkg::idx_mode_e MODE     = gbp_pkg::IDX_CONCAT
) (
  input  logic [PC_W-1:0]      pc,
  input  logic [HIST_BITS-1:0] hist,
  output logic [IDX_W-1:0]     idx
);

  localparam int ADDR_BITS = IDX_W - HIST_BITS;

  generate
    if (MODE == gbp_pkg::IDX_CONCAT) begin : g_join
      assign idx = {pc[PC_LSB +: ADDR_BITS], hist};
    end else begin : g_fold
      assign idx = pc[PC_LSB +: IDX_W] ^ IDX_W'(hist);
    end
  endgenerate

endmodule

// File: rtl/gbp_ctr_table.sv
module gbp_ctr_table #(
  parameter int ENTRIES  = 1024,
  parameter int CTR_BITS = 2,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [CTR_BITS-1:0] rd_ctr,
  input  logic [IDX_W-1:0]    wr_idx,
  output logic [CTR_BITS-1:0] wr_old,
  input  logic                wr_en,
  input  logic [CTR_BITS-1:0] wr_val
);

  localparam logic [CTR_BITS-1:0] WEAK_TAKEN = CTR_BITS'(1) << (CTR_BITS - 1);

  logic [CTR_BITS-1:0] cells [ENTRIES];

  assign rd_ctr = cells[rd_idx];
  assign wr_old = cells[wr_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) cells[i] <= WEAK_TAKEN;
    end else if (wr_en) begin
      cells[wr_idx] <= wr_val;
    end
  end

endmodule

// File: rtl/gbp_corr_predictor.sv
module gbp_corr_predictor #(
  parameter int                 PC_W       = 32,
  parameter int                 PC_LSB     = 2,
  parameter int                 HIST_BITS  = 2,
  parameter int                 CTR_BITS   = 2,
  parameter int                 ENTRIES    = 1024,
  parameter gbp_pkg::idx_mode_e INDEX_MODE = gbp_pkg::IDX_CONCAT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);

  localparam int          IDX_W    = $clog2(ENTRIES);
  localparam int unsigned CTR_TOP  = (1 << CTR_BITS) - 1;
  localparam int unsigned CTR_HALF = 1 << (CTR_BITS - 1);

  // Named internal events, visible to the bound checker.
  logic                 upd_fire;
  logic [HIST_BITS-1:0] hist_q;
  logic [IDX_W-1:0]     pred_idx;
  logic [IDX_W-1:0]     upd_idx;
  logic [CTR_BITS-1:0]  pred_ctr;
  logic [CTR_BITS-1:0]  ctr_old;
  logic [CTR_BITS-1:0]  ctr_new;

  assign upd_fire = upd_valid;

  gbp_history #(.HIST_BITS(HIST_BITS)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (upd_fire),
    .shift_bit (upd_taken),
    .hist_q    (hist_q)
  );

  gbp_index #(
    .PC_W(PC_W), .PC_LSB(PC_LSB), .HIST_BITS(HIST_BITS),
    .IDX_W(IDX_W), .MODE(INDEX_MODE)
  ) u_idx_pred (
    .pc   (pred_pc),
    .hist (hist_q),
    .idx  (pred_idx)
  );

  gbp_index #(
    .PC_W(PC_W), .PC_LSB(PC_LSB), .HIST_BITS(HIST_BITS),
    .IDX_W(IDX_W), .MODE(INDEX_MODE)
  ) u_idx_upd (
    .pc   (upd_pc),
    .hist (hist_q),
    .idx  (upd_idx)
  );

  gbp_ctr_table #(.ENTRIES(ENTRIES), .CTR_BITS(CTR_BITS)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (pred_idx),
    .rd_ctr (pred_ctr),
    .wr_idx (upd_idx),
    .wr_old (ctr_old),
    .wr_en  (upd_fire),
    .wr_val (ctr_new)
  );

  assign ctr_new    = CTR_BITS'(gbp_pkg::ctr_step(32'(ctr_old), upd_taken, CTR_TOP));
  assign pred_taken = gbp_pkg::ctr_says_taken(32'(pred_ctr), CTR_HALF);

endmodule

// File: rtl/gbp_corr_checker.sv
module gbp_corr_checker #(
  parameter int HIST_BITS = 2,
  parameter int CTR_BITS  = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 upd_valid,
  input logic                 upd_taken,
  input logic [HIST_BITS-1:0] hist_q,
  input logic [CTR_BITS-1:0]  ctr_old,
  input logic [CTR_BITS-1:0]  ctr_new
);

  localparam logic [CTR_BITS-1:0] TOP = '1;

  AST_CTR_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && ctr_old != TOP) |-> (ctr_new == ctr_old + 1'b1)); // R2
  AST_CTR_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && ctr_old == TOP) |-> (ctr_new == TOP)); // R2
  AST_CTR_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && ctr_old != '0) |-> (ctr_new == ctr_old - 1'b1)); // R3
  AST_CTR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && ctr_old == '0) |-> (ctr_new == '0)); // R3
  AST_HIST_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (hist_q[0] == $past(upd_taken))); // R5
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(hist_q)); // R5

endmodule

bind gbp_corr_predictor gbp_corr_checker #(
  .HIST_BITS(HIST_BITS), .CTR_BITS(CTR_BITS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .upd_valid (upd_valid),
  .upd_taken (upd_taken),
  .hist_q    (hist_q),
  .ctr_old   (ctr_old),
  .ctr_new   (ctr_new)
);

// File: tb/gbp_corr_predictor_tb.sv
module gbp_corr_predictor_tb;

  localparam int CLK_PERIOD = 10;
  localparam int M    = 2;
  localparam int N    = 2;
  localparam int ENT  = 1024;
  localparam int TOPV = (1 << N) - 1;
  localparam int HALF = 1 << (N - 1);
  localparam int ABITS = 10 - M;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pred_pc = '0;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic        pt_cat, pt_xor;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int mc [ENT];
  int mx [ENT];
  int h;

  bit    exp_c [$];
  bit    exp_x [$];
  string req_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gbp_corr_predictor #(.INDEX_MODE(gbp_pkg::IDX_CONCAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pt_cat),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

  gbp_corr_predictor #(.INDEX_MODE(gbp_pkg::IDX_XOR)) u_dut_xor (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pt_xor),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

  // Model index rules, stated arithmetically (R6, R7).
  function automatic int icat(input logic [31:0] pc, input int hh);
    return (int'((pc >> 2) % (1 << ABITS)) * (1 << M)) + hh;
  endfunction
  function automatic int ixor(input logic [31:0] pc, input int hh);
    return int'((pc >> 2) % ENT) ^ hh;
  endfunction
  function automatic int bump(input int v, input bit t);
    if (t) return (v == TOPV) ? v : v + 1;
    return (v == 0) ? 0 : v - 1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < ENT; i++) begin mc[i] = HALF; mx[i] = HALF; end
    h = 0;
  endtask

  // Driver: one cycle of lookup plus optional training; pushes expectations.
  task automatic step(input logic [31:0] ppc, input bit uv,
                      input logic [31:0] upc, input bit ut, input string req);
    @(posedge clk); #1;
    pred_pc = ppc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
    exp_c.push_back(mc[icat(ppc, h)] >= HALF);
    exp_x.push_back(mx[ixor(ppc, h)] >= HALF);
    req_q.push_back(req);
    if (uv) begin
      mc[icat(upc, h)] = bump(mc[icat(upc, h)], ut);
      mx[ixor(upc, h)] = bump(mx[ixor(upc, h)], ut);
      h = ((h << 1) | int'(ut)) % (1 << M);
    end
  endtask

  task automatic train(input logic [31:0] pc, input bit t, input string req);
    step(pc, 1'b1, pc, t, req);
  endtask

  task automatic look(input logic [31:0] pc, input string req);
    step(pc, 1'b0, '0, 1'b0, req);
  endtask

  // Monitor: compares away from the active edge.
  always @(negedge clk) begin
    if (req_q.size() > 0) begin
      bit ec, ex;
      string r;
      ec = exp_c.pop_front(); ex = exp_x.pop_front(); r = req_q.pop_front();
      checks += 2;
      if (pt_cat !== ec) begin
        errors++;
        $display("FAIL %s joined-mode guess: actual %0b expected %0b", r, pt_cat, ec);
      end
      if (pt_xor !== ex) begin
        errors++;
        $display("FAIL %s folded-mode guess: actual %0b expected %0b", r, pt_xor, ex);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    logic [31:0] pa, pb, palias;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    pa = 32'h0000_0040;
    pb = 32'h0000_0084;
    palias = pa + (32'h1 << (2 + 10));  // equal below the index bits in both modes

    // R1: everything predicts taken after reset
    look(32'h0, "R1");
    look(32'hFFFF_FFFC, "R1");
    look(pa, "R1");

    // R3, R4: drive one counter to the floor and past it
    repeat (6) train(pa, 1'b0, "R3");
    look(pa, "R3");
    train(pa, 1'b1, "R4");   // 0 -> 1, still below half
    look(pa, "R4");
    train(pa, 1'b1, "R4");
    look(pa, "R4");

    // R2: saturate at the top, one not-taken keeps it taken
    repeat (6) train(pb, 1'b1, "R2");
    train(pb, 1'b0, "R2");
    look(pb, "R2");

    // R10: alias trained, original read
    repeat (4) train(palias, 1'b0, "R10");
    look(pa, "R10");

    // R5, R8: alternating outcomes select different history slots
    for (int k = 0; k < 12; k++) train(pb, k[0], "R8");
    look(pb, "R5");

    // R9: lookup and training together on the same address
    for (int k = 0; k < 10; k++) step(pa, 1'b1, pa, k[1], "R9");

    // R6, R7: pseudo-random mix over a small address pool with aliasing
    lfsr = 32'hACE1_2345;
    for (int k = 0; k < 600; k++) begin
      logic [31:0] p1, p2;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      p1 = {18'h0, lfsr[3], 3'b0, lfsr[5:4], 6'h0, 2'b00} + (lfsr[9] ? 32'h1000 : 32'h0);
      p2 = lfsr[10] ? p1 : {18'h0, lfsr[13], 3'b0, lfsr[12:11], 6'h0, 2'b00};
      step(p2, lfsr[7] | lfsr[8], p1, lfsr[6] ^ lfsr[14], lfsr[15] ? "R6" : "R7");
    end

    @(posedge clk); #1 upd_valid = 1'b0;
    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule